// File: doc/BRIEF.md
# Single-Pixel Frame Grabber with Frame Statistics

This block sits on the register side of an image path that delivers an 18x18 image of 6-bit pixels as a stream. A start-of-frame strobe marks the first pixel and a valid strobe qualifies every pixel. From each frame the block keeps exactly one pixel: the one at its internal pointer. A host reading one register repeatedly can therefore pull a full image out over many frames, one pixel per frame, without any image buffer.

Alongside the grabber, a statistics unit tracks the brightest pixel, the darkest pixel and a scaled pixel sum over each complete frame. The three results are published together when the last pixel of a full frame arrives.

The host port has a read strobe, a write strobe, a 2-bit register address and a registered read-data byte that is valid from the clock edge that follows the read strobe. Register addresses are 0 for the pixel register, 1 for the maximum, 2 for the minimum and 3 for the scaled sum.

Top module: `pixel_grabber`

## Requirements
- R1: After reset the pixel register reads 0x00, the maximum reads 0x00, the minimum reads 0x3F and the sum reads 0x00.
- R2: A read of address 0 that returns a captured pixel gives bit 7 = 1 only when that pixel is index 0 of the frame, bit 6 = 1 (data valid) and the pixel value in bits 5:0.
- R3: A write to address 0 moves the pointer to pixel index 0 and arms the grabber, so the next valid pixel read has bit 7 set and holds pixel index 0.
- R4: After arming, the pixel is taken from the first frame whose start-of-frame arrives after the arming edge; a frame already in progress, including one starting in the arming cycle, is not used.
- R5: A read of address 0 that returns data valid advances the pointer by one and re-arms; after index 323 the pointer returns to index 0 and the next valid read has bit 7 set.
- R6: A read of address 0 made before the armed capture has completed returns 0x00 and leaves the pointer unchanged; the pending capture stays armed.
- R7: At the end of each complete frame of 324 valid pixels, address 1 holds the frame's largest and address 2 its smallest pixel value, in bits 5:0 with bits 7:6 zero.
- R8: At the end of each complete frame, address 3 holds the 15-bit sum of its 324 pixels shifted right by 7, which is 159 for a frame of all 63.
- R9: The three statistics change together only at the last pixel of a complete frame; a frame cut short by a new start-of-frame leaves them unchanged, and a read in the cycle of the last pixel returns the previous frame's values.
- R10: Writes to addresses 1, 2 and 3 have no effect on the values read back from them.
- R11: A read of address 0 in the same cycle as the armed pixel arrives returns 0x00, and the capture still completes so that the following read returns that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Marks the first pixel of a frame, qualified by pix_valid_i |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_i | input | 6 | Pixel value |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 pixel, 1 max, 2 min, 3 sum |
| rdata_o | output | 8 | Read data, updated on the edge that samples rd_i |

## Verification
The host read of the pixel register and the landing of the armed capture can fall into one clock edge. The bench provokes this by rewinding the pointer to index 0 and then driving the read strobe in the very cycle that carries the start-of-frame pixel. The read taken in that cycle must come back as 0x00, and the next read must return the same pixel with bits 7 and 6 set. A second overlap, a statistics read in the cycle of a frame's last pixel, is judged by requiring the previous frame's maximum.

// File: rtl/pgrab_pkg.sv
package pgrab_pkg;
  parameter int IMG_W = 18;
  parameter int IMG_H = 18;
  parameter int PIX_W = 6;
  parameter int REG_W = 8;
  parameter int ADDR_W = 2;

  localparam int NPIX = IMG_W * IMG_H;
  localparam int IDX_W = $clog2(NPIX);
  localparam int PIX_MAXV = (1 << PIX_W) - 1;
  localparam int SUM_W = $clog2(NPIX * PIX_MAXV + 1);
  localparam int SUM_SHIFT = SUM_W - REG_W;
  localparam int SUM_TOP = (NPIX * PIX_MAXV) >> SUM_SHIFT;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIX = 2'd0,
    REG_MAX = 2'd1,
    REG_MIN = 2'd2,
    REG_SUM = 2'd3
  } reg_addr_e;

  typedef struct packed {
    pix_t max;
    pix_t min;
    reg_t sum;
  } stats_t;
endpackage

// File: rtl/pgrab_frame_idx.sv
module pgrab_frame_idx
  import pgrab_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic valid_i,
  output idx_t idx_o,
  output logic live_o,
  output logic first_o,
  output logic last_o
);
  idx_t cnt_q;
  logic in_frame_q;

  assign first_o = valid_i && sof_i;
  // pixels outside a started frame are not counted
  assign live_o  = valid_i && (sof_i || in_frame_q);
  assign idx_o   = sof_i ? '0 : cnt_q;
  assign last_o  = live_o && (idx_o == idx_t'(NPIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (live_o) begin
      cnt_q      <= last_o ? '0 : idx_o + 1'b1;
      in_frame_q <= !last_o;
    end
  end
endmodule

// File: rtl/pgrab_capture.sv
module pgrab_capture
  import pgrab_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_i,
  input  logic live_i,
  input  idx_t idx_i,
  input  pix_t pix_i,
  input  logic acc_rd_i,
  input  logic acc_wr_i,
  output reg_t byte_o,
  output idx_t ptr_o
);
  typedef enum logic [1:0] {CAP_WAIT, CAP_SCAN, CAP_HELD} cap_st_e;

  cap_st_e st_q;
  idx_t    ptr_q;
  pix_t    hold_q;
  logic    hit;

  assign hit = live_i && (idx_i == ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CAP_WAIT;
      ptr_q  <= '0;
      hold_q <= '0;
    end else if (acc_wr_i) begin
      ptr_q <= '0;
      st_q  <= CAP_WAIT;
    end else if (acc_rd_i && st_q == CAP_HELD) begin
      ptr_q <= (ptr_q == idx_t'(NPIX - 1)) ? '0 : ptr_q + 1'b1;
      st_q  <= CAP_WAIT;
    end else begin
      unique case (st_q)
        CAP_WAIT: if (first_i) begin
          if (hit) begin
            hold_q <= pix_i;
            st_q   <= CAP_HELD;
          end else begin
            st_q <= CAP_SCAN;
          end
        end
        CAP_SCAN: if (hit) begin
          hold_q <= pix_i;
          st_q   <= CAP_HELD;
        end
        default: ;
      endcase
    end
  end

  assign byte_o = (st_q == CAP_HELD) ? {ptr_q == '0, 1'b1, hold_q} : '0;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/pgrab_stats.sv
module pgrab_stats
  import pgrab_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   live_i,
  input  logic   first_i,
  input  logic   last_i,
  input  pix_t   pix_i,
  output stats_t stats_o
);
  pix_t             acc_max_q, acc_min_q, nxt_max, nxt_min;
  logic [SUM_W-1:0] acc_sum_q, nxt_sum;
  stats_t           stats_q;

  always_comb begin
    if (first_i) begin
      nxt_max = pix_i;
      nxt_min = pix_i;
      nxt_sum = SUM_W'(pix_i);
    end else begin
      nxt_max = (pix_i > acc_max_q) ? pix_i : acc_max_q;
      nxt_min = (pix_i < acc_min_q) ? pix_i : acc_min_q;
      nxt_sum = acc_sum_q + SUM_W'(pix_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_max_q <= '0;
      acc_min_q <= '1;
      acc_sum_q <= '0;
    end else if (live_i) begin
      acc_max_q <= nxt_max;
      acc_min_q <= nxt_min;
      acc_sum_q <= nxt_sum;
    end
  end

  // publish all three together so a read never mixes frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stats_q.max <= '0;
      stats_q.min <= '1;
      stats_q.sum <= '0;
    end else if (last_i) begin
      stats_q.max <= nxt_max;
      stats_q.min <= nxt_min;
      stats_q.sum <= nxt_sum[SUM_W-1:SUM_SHIFT];
    end
  end

  assign stats_o = stats_q;
endmodule

// File: rtl/pixel_grabber.sv
module pixel_grabber
  import pgrab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REG_W-1:0]  rdata_o
);
  idx_t   idx, cap_ptr;
  logic   live, first, last;
  logic   acc_rd, acc_wr;
  reg_t   cap_byte, rd_mux, rdata_q;
  stats_t stat_q;

  assign acc_wr = wr_i && (addr_i == REG_PIX);
  assign acc_rd = rd_i && !wr_i && (addr_i == REG_PIX);

  pgrab_frame_idx u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sof_i   (sof_i),
    .valid_i (pix_valid_i),
    .idx_o   (idx),
    .live_o  (live),
    .first_o (first),
    .last_o  (last)
  );

  pgrab_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (first),
    .live_i   (live),
    .idx_i    (idx),
    .pix_i    (pix_i),
    .acc_rd_i (acc_rd),
    .acc_wr_i (acc_wr),
    .byte_o   (cap_byte),
    .ptr_o    (cap_ptr)
  );

  pgrab_stats u_stats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .live_i  (live),
    .first_i (first),
    .last_i  (last),
    .pix_i   (pix_i),
    .stats_o (stat_q)
  );

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_PIX: rd_mux = cap_byte;
      REG_MAX: rd_mux = {{(REG_W - PIX_W){1'b0}}, stat_q.max};
      REG_MIN: rd_mux = {{(REG_W - PIX_W){1'b0}}, stat_q.min};
      default: rd_mux = stat_q.sum;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pixel_grabber_chk.sv
module pixel_grabber_chk
  import pgrab_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              pix_valid_i,
  input logic [REG_W-1:0]  rdata_o,
  input idx_t              cap_ptr_i,
  input stats_t            stat_i
);
  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ptr_i < idx_t'(NPIX)); // R5

  AST_PTR_ONLY_ON_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> $stable(cap_ptr_i)); // R5

  AST_WRITE_REWINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_PIX) |=> cap_ptr_i == '0); // R3

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == REG_PIX) |=> (rdata_o[PIX_W] || rdata_o == '0)); // R6

  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R2

  AST_SUM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i.sum <= reg_t'(SUM_TOP)); // R8

  AST_STATS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(stat_i)); // R9
endmodule

bind pixel_grabber pixel_grabber_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .pix_valid_i (pix_valid_i),
  .rdata_o     (rdata_o),
  .cap_ptr_i   (cap_ptr),
  .stat_i      (stat_q)
);

// File: tb/pixel_grabber_bench.sv
module pixel_grabber_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 324;
  localparam int WATCHDOG = 180000;
  localparam int NVEC = 6;
  // {pattern mode, seed}
  localparam int VEC [NVEC][2] = '{'{0, 63}, '{0, 0}, '{1, 0}, '{1, 17}, '{2, 5}, '{2, 40}};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sof_i = 1'b0, pix_valid_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [5:0] pix_i = '0;
  logic [1:0] addr_i = '0;
  logic [7:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  int act_data;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pixel_grabber u_pixel_grabber (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .pix_valid_i(pix_valid_i),
    .pix_i(pix_i), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .rdata_o(rdata_o)
  );

  function automatic int pat(int mode, int seed, int i);
    case (mode)
      0:       return seed & 63;
      1:       return (i * 5 + seed) & 63;
      default: return (i * i + seed) & 63;
    endcase
  endfunction

  function automatic int exp_max(int mode, int seed);
    int m = 0;
    for (int i = 0; i < NP; i++) if (pat(mode, seed, i) > m) m = pat(mode, seed, i);
    return m;
  endfunction

  function automatic int exp_min(int mode, int seed);
    int m = 63;
    for (int i = 0; i < NP; i++) if (pat(mode, seed, i) < m) m = pat(mode, seed, i);
    return m;
  endfunction

  function automatic int exp_sum(int mode, int seed);
    int s = 0;
    for (int i = 0; i < NP; i++) s += pat(mode, seed, i);
    return s >> 7;
  endfunction

  function automatic int pix_byte(int idx, int val);
    return ((idx == 0) ? 128 : 0) | 64 | val;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd_reg(int a, output int d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = 2'(a);
    @(negedge clk_i);
    rd_i = 1'b0;
    d = int'(rdata_o);
  endtask

  task automatic wr_reg(int a);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 2'(a);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  // act_idx >= 0 drives a read of act_addr in the cycle of that pixel
  task automatic send_frame(int mode, int seed, int len, int act_idx, int act_addr);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      if (i == act_idx + 1) act_data = int'(rdata_o);
      sof_i = (i == 0);
      pix_valid_i = 1'b1;
      pix_i = 6'(pat(mode, seed, i));
      rd_i = (i == act_idx);
      addr_i = (i == act_idx) ? 2'(act_addr) : 2'd0;
    end
    @(negedge clk_i);
    if (act_idx == len - 1) act_data = int'(rdata_o);
    sof_i = 1'b0; pix_valid_i = 1'b0; rd_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int d, pmax, pmin, psum;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values
    rd_reg(0, d); chk("R1", "pixel after reset", d, 8'h00);
    rd_reg(1, d); chk("R1", "max after reset", d, 8'h00);
    rd_reg(2, d); chk("R1", "min after reset", d, 8'h3F);
    rd_reg(3, d); chk("R1", "sum after reset", d, 8'h00);

    // R7 / R8 statistics over the vector table
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][0], VEC[v][1], NP, -1, 0);
      rd_reg(1, d); chk("R7", "frame max", d, exp_max(VEC[v][0], VEC[v][1]));
      rd_reg(2, d); chk("R7", "frame min", d, exp_min(VEC[v][0], VEC[v][1]));
      rd_reg(3, d); chk("R8", "scaled sum", d, exp_sum(VEC[v][0], VEC[v][1]));
    end
    chk("R8", "sum of all-63 frame", exp_sum(0, 63), 159);
    pmax = exp_max(2, 40); pmin = exp_min(2, 40); psum = exp_sum(2, 40);

    // R10 writes to statistics addresses are ignored
    wr_reg(1); wr_reg(2); wr_reg(3);
    rd_reg(1, d); chk("R10", "max after write", d, pmax);
    rd_reg(2, d); chk("R10", "min after write", d, pmin);
    rd_reg(3, d); chk("R10", "sum after write", d, psum);

    // R9 short frame leaves stats; read at last pixel sees old frame
    send_frame(0, 9, 100, -1, 0);
    rd_reg(1, d); chk("R9", "max after short frame", d, pmax);
    rd_reg(3, d); chk("R9", "sum after short frame", d, psum);
    send_frame(0, 33, NP, NP - 1, 1);
    chk("R9", "max read at last pixel", act_data, pmax);
    rd_reg(1, d); chk("R9", "max after full frame", d, 33);
    rd_reg(2, d); chk("R9", "min after full frame", d, 33);

    // R3 / R2 rewind and pixel byte format
    wr_reg(0);
    send_frame(1, 3, NP, -1, 0);
    rd_reg(0, d); chk("R3", "first pixel after rewind", d, pix_byte(0, pat(1, 3, 0)));
    chk("R2", "sof and valid bits", d >> 6, 3);

    // R6 read before capture: zero, pointer kept
    rd_reg(0, d); chk("R6", "read before capture", d, 8'h00);
    send_frame(1, 3, NP, -1, 0);
    rd_reg(0, d); chk("R6", "pointer not advanced", d, pix_byte(1, pat(1, 3, 1)));

    // R4 arming in a frame's first cycle skips that frame
    send_frame(1, 50, NP, -1, 0);
    send_frame(1, 20, NP, 0, 0);
    chk("R5", "read during frame start", act_data, pix_byte(2, pat(1, 50, 2)));
    send_frame(1, 30, NP, -1, 0);
    rd_reg(0, d); chk("R4", "pixel from next frame", d, pix_byte(3, pat(1, 30, 3)));

    // R11 read collides with capture of pixel 0
    wr_reg(0);
    send_frame(1, 44, NP, 0, 0);
    chk("R11", "read in capture cycle", act_data, 8'h00);
    rd_reg(0, d); chk("R11", "capture kept", d, pix_byte(0, pat(1, 44, 0)));

    // R5 full image dump with wrap
    wr_reg(0);
    for (int k = 0; k <= NP; k++) begin
      send_frame(1, 7, NP, -1, 0);
      rd_reg(0, d);
      chk("R5", "dump pixel", d, pix_byte(k % NP, pat(1, 7, k % NP)));
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule